// File: doc/BRIEF.md
# Binary Hit Trigger-Matching Readout

This block watches a bank of single-bit discriminator outputs and records the state of every channel on every clock into a circular sample history. Triggers arrive at a fixed delay after the physics event they belong to. For each trigger, the block looks back by that delay, scans a fixed-length acceptance window of stored samples and collects every channel that turned on inside it. The result goes out as one framed record on a byte-wide valid/ready stream.

A frame holds a 12-byte header, one 2-byte entry per hit and a 4-byte trailer. The header identifies the board, the trigger and the absolute time of the window. Each entry gives the channel and the position of the hit inside the window. The trailer gives the number of entries and an error flag. Triggers that arrive while a frame is still being built wait in a short queue. A trigger that finds the queue full is discarded, and this is flagged in a later trailer. Channel count, trigger delay, window length, history depth and queue depth are parameters. The board identity is an input.

Top module: `hit_window_readout`

## Requirements
- R1: After reset, `out_valid_o` stays low until a trigger has been received. The sample timestamp starts at 0 on the first clock after reset and advances by one every clock.
- R2: Every frame begins with 12 header bytes, each multi-byte field most significant byte first: bytes 0-1 are `board_id_i`; bytes 2-5 are the 32-bit frame ID; bytes 6-9 are the 32-bit timestamp of the first window sample; bytes 10-11 are zero. The frame ID is the number of triggers received since reset before this one, counting dropped triggers.
- R3: A trigger sampled at timestamp T covers samples T-LATENCY through T-LATENCY+WINDOW-1. A hit in sample T-LATENCY+k is reported with index k, so samples outside that range give no entry.
- R4: Each hit entry is two bytes: first the channel number, then the index of the sample inside the window.
- R5: Channel c has an entry at index k only if its bit is 1 in window sample k and 0 in the sample just before it. A level held across several samples therefore gives one entry, at its rising edge, and a level already high before the window gives none.
- R6: Entries are ordered by ascending sample index and, within one index, by ascending channel number.
- R7: Every frame ends with 4 trailer bytes: bytes 0-1 are the entry count (most significant byte first); byte 2 holds the error flag in bit 0, with its other bits zero; byte 3 is zero. `out_last_o` is high on the last trailer byte and on no other byte.
- R8: Up to TQ_DEPTH triggers can wait while a frame is in progress. An idle framer takes a waiting trigger on the clock after it is queued. Waiting triggers give their frames in arrival order.
- R9: A trigger that arrives while the queue holds TQ_DEPTH entries produces no frame. It sets the error flag in the next trailer that starts after the drop, and the flag is clear again in the trailer after that.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and processing clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hits_i | input | NCH | Discriminator level per channel, stored every clock |
| trig_i | input | 1 | Fixed-delay trigger request, one clock per trigger |
| board_id_i | input | 16 | Board identity placed in each header |
| out_data_o | output | 8 | Frame byte |
| out_valid_o | output | 1 | Frame byte is valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_last_o | output | 1 | Marks the final byte of a frame |

## Verification
The window search is driven with single pulses placed at the first and last window index, one sample past the end, and straddling the start. These placements separate a correct window boundary from one that is off by one in either direction, and they show whether a level that began before the window is reported. Multi-channel patterns check ordering: several channels at one index, one channel rising twice after a gap, and an all-channel row. These tell the required index-then-channel order apart from a channel-first order, and show whether re-arming of a channel works. A burst of four triggers on consecutive clocks separates correct queueing, dropping and error-flag timing from a queue that is one entry off. The last runs apply irregular backpressure to confirm that the stream content does not depend on `out_ready_i`.

// File: rtl/hwr_pkg.sv
`timescale 1ns/1ps
package hwr_pkg;
    localparam int TS_W      = 32;
    localparam int FID_W     = 32;
    localparam int HDR_BYTES = 12;
    localparam int TRL_BYTES = 4;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [FID_W-1:0] fid;
    } trig_ent_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_HDR,
        FR_SCAN,
        FR_TRL
    } fr_state_e;
endpackage

// File: rtl/hwr_history.sv
`timescale 1ns/1ps
module hwr_history
    import hwr_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NCH-1:0]  hits_i,
    output logic [TS_W-1:0] ts_o,
    input  logic [AW-1:0]   rd_cur_addr_i,
    input  logic [AW-1:0]   rd_prev_addr_i,
    output logic [NCH-1:0]  rd_cur_o,
    output logic [NCH-1:0]  rd_prev_o
);
    logic [NCH-1:0]  ring_q [DEPTH];
    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q + 32'd1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ts_q <= '0;
            for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
        end else begin
            ts_q <= ts_d;
            ring_q[ts_q[AW-1:0]] <= hits_i;
        end
    end

    assign ts_o      = ts_q;
    assign rd_cur_o  = ring_q[rd_cur_addr_i];
    assign rd_prev_o = ring_q[rd_prev_addr_i];
endmodule

// File: rtl/hwr_trig_fifo.sv
`timescale 1ns/1ps
module hwr_trig_fifo
    import hwr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      push_i,
    input  trig_ent_t din_i,
    input  logic      pop_i,
    output trig_ent_t dout_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t      ptr_d, ptr_q;
    trig_ent_t mem_q [DEPTH];
    logic      do_push;

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push_i && (ptr_q.cnt != CW'(DEPTH));
        if (do_push) ptr_d.wr = (ptr_q.wr == PW'(DEPTH-1)) ? '0 : ptr_q.wr + PW'(1);
        if (pop_i)   ptr_d.rd = (ptr_q.rd == PW'(DEPTH-1)) ? '0 : ptr_q.rd + PW'(1);
        ptr_d.cnt = ptr_q.cnt + CW'(do_push) - CW'(pop_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ptr_q <= '0;
        else       ptr_q <= ptr_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[ptr_q.wr] <= din_i;
    end

    assign dout_o  = mem_q[ptr_q.rd];
    assign empty_o = (ptr_q.cnt == '0);
    assign full_o  = (ptr_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/hwr_framer.sv
`timescale 1ns/1ps
module hwr_framer
    import hwr_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int WINDOW  = 12,
    parameter int LATENCY = 24,
    parameter int AW      = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [15:0]     board_id_i,
    input  trig_ent_t       ent_i,
    input  logic            empty_i,
    input  logic            drop_i,
    output logic            pop_o,
    output logic [AW-1:0]   rd_cur_addr_o,
    output logic [AW-1:0]   rd_prev_addr_o,
    input  logic [NCH-1:0]  cur_i,
    input  logic [NCH-1:0]  prev_i,
    output logic [7:0]      out_data_o,
    output logic            out_valid_o,
    input  logic            out_ready_i,
    output logic            out_last_o
);
    localparam int RW  = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        fr_state_e        st;
        logic [3:0]       bidx;
        logic [RW-1:0]    row;
        logic             second;
        logic [NCH-1:0]   done;
        logic [15:0]      bid;
        logic [FID_W-1:0] fid;
        logic [TS_W-1:0]  wstart;
        logic [15:0]      nhit;
        logic             err;
        logic             err_snap;
    } fr_t;

    fr_t            fr_d, fr_q;
    logic [NCH-1:0] fresh;
    logic [CHW-1:0] pick;
    logic [7:0]     hdr_byte, trl_byte;

    always_comb begin
        rd_cur_addr_o  = fr_q.wstart[AW-1:0] + AW'(fr_q.row);
        rd_prev_addr_o = rd_cur_addr_o - AW'(1);
        fresh = cur_i & ~prev_i & ~fr_q.done;
        pick  = '0;
        for (int c = NCH-1; c >= 0; c--) begin
            if (fresh[c]) pick = CHW'(c);
        end

        case (fr_q.bidx)
            4'd0:    hdr_byte = fr_q.bid[15:8];
            4'd1:    hdr_byte = fr_q.bid[7:0];
            4'd2:    hdr_byte = fr_q.fid[31:24];
            4'd3:    hdr_byte = fr_q.fid[23:16];
            4'd4:    hdr_byte = fr_q.fid[15:8];
            4'd5:    hdr_byte = fr_q.fid[7:0];
            4'd6:    hdr_byte = fr_q.wstart[31:24];
            4'd7:    hdr_byte = fr_q.wstart[23:16];
            4'd8:    hdr_byte = fr_q.wstart[15:8];
            4'd9:    hdr_byte = fr_q.wstart[7:0];
            default: hdr_byte = 8'h00;
        endcase

        case (fr_q.bidx)
            4'd0:    trl_byte = fr_q.nhit[15:8];
            4'd1:    trl_byte = fr_q.nhit[7:0];
            4'd2:    trl_byte = {7'b0, fr_q.err_snap};
            default: trl_byte = 8'h00;
        endcase

        fr_d        = fr_q;
        fr_d.err    = fr_q.err | drop_i;
        pop_o       = 1'b0;
        out_valid_o = 1'b0;
        out_data_o  = 8'h00;
        out_last_o  = 1'b0;

        case (fr_q.st)
            FR_IDLE: begin
                if (!empty_i) begin
                    pop_o       = 1'b1;
                    fr_d.st     = FR_HDR;
                    fr_d.bidx   = '0;
                    fr_d.row    = '0;
                    fr_d.second = 1'b0;
                    fr_d.done   = '0;
                    fr_d.nhit   = '0;
                    fr_d.bid    = board_id_i;
                    fr_d.fid    = ent_i.fid;
                    fr_d.wstart = ent_i.ts - TS_W'(LATENCY);
                end
            end
            FR_HDR: begin
                out_valid_o = 1'b1;
                out_data_o  = hdr_byte;
                if (out_ready_i) begin
                    if (fr_q.bidx == 4'(HDR_BYTES-1)) begin
                        fr_d.st   = FR_SCAN;
                        fr_d.bidx = '0;
                    end else begin
                        fr_d.bidx = fr_q.bidx + 4'd1;
                    end
                end
            end
            FR_SCAN: begin
                if (|fresh) begin
                    out_valid_o = 1'b1;
                    out_data_o  = fr_q.second ? 8'(fr_q.row) : 8'(pick);
                    if (out_ready_i) begin
                        fr_d.second = !fr_q.second;
                        if (fr_q.second) begin
                            fr_d.done = fr_q.done | (NCH'(1) << pick);
                            fr_d.nhit = fr_q.nhit + 16'd1;
                        end
                    end
                end else begin
                    fr_d.done   = '0;
                    fr_d.second = 1'b0;
                    if (fr_q.row == RW'(WINDOW-1)) begin
                        fr_d.st       = FR_TRL;
                        fr_d.bidx     = '0;
                        fr_d.err_snap = fr_q.err | drop_i;
                        fr_d.err      = 1'b0;
                    end else begin
                        fr_d.row = fr_q.row + RW'(1);
                    end
                end
            end
            FR_TRL: begin
                out_valid_o = 1'b1;
                out_data_o  = trl_byte;
                out_last_o  = (fr_q.bidx == 4'(TRL_BYTES-1));
                if (out_ready_i) begin
                    if (fr_q.bidx == 4'(TRL_BYTES-1)) fr_d.st = FR_IDLE;
                    else                              fr_d.bidx = fr_q.bidx + 4'd1;
                end
            end
            default: fr_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) fr_q <= '0;
        else       fr_q <= fr_d;
    end
endmodule

// File: rtl/hit_window_readout.sv
`timescale 1ns/1ps
module hit_window_readout
    import hwr_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int LATENCY    = 24,
    parameter int WINDOW     = 12,
    parameter int HIST_DEPTH = 256,
    parameter int TQ_DEPTH   = 2
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NCH-1:0] hits_i,
    input  logic           trig_i,
    input  logic [15:0]    board_id_i,
    output logic [7:0]     out_data_o,
    output logic           out_valid_o,
    input  logic           out_ready_i,
    output logic           out_last_o
);
    localparam int AW = $clog2(HIST_DEPTH);

    typedef struct packed {
        logic [FID_W-1:0] ntrig;
    } top_t;

    top_t            top_d, top_q;
    logic [TS_W-1:0] ts;
    trig_ent_t       q_din, q_dout;
    logic            q_pop, q_empty, q_full, q_drop;
    logic [AW-1:0]   rd_cur_addr, rd_prev_addr;
    logic [NCH-1:0]  rd_cur, rd_prev;

    always_comb begin
        top_d = top_q;
        if (trig_i) top_d.ntrig = top_q.ntrig + 32'd1;
        q_drop = trig_i & q_full;
        q_din  = '{ts: ts, fid: top_q.ntrig};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) top_q <= '0;
        else       top_q <= top_d;
    end

    hwr_history #(.NCH(NCH), .DEPTH(HIST_DEPTH), .AW(AW)) hist_i (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .hits_i         (hits_i),
        .ts_o           (ts),
        .rd_cur_addr_i  (rd_cur_addr),
        .rd_prev_addr_i (rd_prev_addr),
        .rd_cur_o       (rd_cur),
        .rd_prev_o      (rd_prev)
    );

    hwr_trig_fifo #(.DEPTH(TQ_DEPTH)) tq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (trig_i),
        .din_i   (q_din),
        .pop_i   (q_pop),
        .dout_o  (q_dout),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    hwr_framer #(.NCH(NCH), .WINDOW(WINDOW), .LATENCY(LATENCY), .AW(AW)) fr_i (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .board_id_i     (board_id_i),
        .ent_i          (q_dout),
        .empty_i        (q_empty),
        .drop_i         (q_drop),
        .pop_o          (q_pop),
        .rd_cur_addr_o  (rd_cur_addr),
        .rd_prev_addr_o (rd_prev_addr),
        .cur_i          (rd_cur),
        .prev_i         (rd_prev),
        .out_data_o     (out_data_o),
        .out_valid_o    (out_valid_o),
        .out_ready_i    (out_ready_i),
        .out_last_o     (out_last_o)
    );
endmodule

// File: rtl/hwr_checker.sv
`timescale 1ns/1ps
module hwr_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic [7:0] out_data_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic       out_last_o,
    input logic       q_pop,
    input logic       q_empty
);
    p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !out_valid_o);

    p_hold_on_stall_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    p_last_is_valid_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        out_last_o |-> out_valid_o);

    p_single_last_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_last_o && out_ready_i) |=> !out_last_o);

    p_pop_needs_entry_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        q_pop |-> !q_empty);
endmodule

bind hit_window_readout hwr_checker chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_last_o  (out_last_o),
    .q_pop       (q_pop),
    .q_empty     (q_empty)
);

// File: tb/hit_window_readout_tb_top.sv
`timescale 1ns/1ps
module hit_window_readout_tb_top;
    localparam int NCH = 8;
    localparam int LAT = 24;
    localparam int WIN = 12;
    localparam int TQ  = 2;
    localparam logic [15:0] BID = 16'hB5C3;
    localparam int NVEC = 8;
    // fields: [31:24] channel mask, [23:16] signed start index, [15:8] length, [7:0] expected entries
    localparam logic [31:0] VEC [NVEC] = '{
        32'h01_00_03_01,
        32'h81_05_01_02,
        32'hFF_0B_01_08,
        32'h10_0C_02_00,
        32'h04_FF_04_00,
        32'h0F_03_14_04,
        32'h00_00_00_00,
        32'hAA_00_01_04
    };

    logic           clk = 1'b0;
    logic           rst_i = 1'b1;
    logic [NCH-1:0] hits_i = '0;
    logic           trig_i = 1'b0;
    logic [7:0]     out_data_o;
    logic           out_valid_o;
    logic           out_ready_i = 1'b1;
    logic           out_last_o;

    int   nchk = 0;
    int   nfail = 0;
    int   tsn = 0;
    int   fidn = 0;
    int   nlast = 0;
    int   nframes = 0;
    bit   stall = 1'b0;
    logic [7:0] hist [0:4095];
    logic [7:0] pat  [0:LAT+2];
    logic [7:0] rxq [$];
    bit         rxl [$];
    logic [7:0] expq [$];
    bit         expl [$];
    int         trig_ts [$];
    int         trig_fid [$];

    always #10 clk = ~clk;

    hit_window_readout #(.NCH(NCH), .LATENCY(LAT), .WINDOW(WIN), .HIST_DEPTH(256), .TQ_DEPTH(TQ)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .hits_i      (hits_i),
        .trig_i      (trig_i),
        .board_id_i  (BID),
        .out_data_o  (out_data_o),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .out_last_o  (out_last_o)
    );

    always @(negedge clk) begin
        if (!rst_i && out_valid_o && out_ready_i) begin
            rxq.push_back(out_data_o);
            rxl.push_back(out_last_o);
            if (out_last_o) nlast++;
        end
    end

    task automatic check(input bit ok, input string req, input string act, input string exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] h, input bit t);
        hits_i = h;
        trig_i = t;
        hist[tsn] = h;
        out_ready_i = stall ? ((tsn % 3) != 2) : 1'b1;
        if (t) begin
            trig_ts.push_back(tsn);
            trig_fid.push_back(fidn);
            fidn++;
        end
        @(posedge clk);
        #2;
        tsn++;
    endtask

    task automatic pushb(input logic [7:0] b, input bit l);
        expq.push_back(b);
        expl.push_back(l);
    endtask

    // expected frame from R2..R7
    task automatic build(input int t, input int fid, input bit err);
        int s;
        int cnt;
        logic [31:0] f;
        logic [31:0] sw;
        s = t - LAT;
        f = fid;
        sw = s;
        cnt = 0;
        pushb(BID[15:8], 0); pushb(BID[7:0], 0);
        pushb(f[31:24], 0); pushb(f[23:16], 0); pushb(f[15:8], 0); pushb(f[7:0], 0);
        pushb(sw[31:24], 0); pushb(sw[23:16], 0); pushb(sw[15:8], 0); pushb(sw[7:0], 0);
        pushb(8'h00, 0); pushb(8'h00, 0);
        for (int k = 0; k < WIN; k++) begin
            for (int c = 0; c < NCH; c++) begin
                if (hist[s+k][c] && !hist[s+k-1][c]) begin
                    pushb(8'(c), 0);
                    pushb(8'(k), 0);
                    cnt++;
                end
            end
        end
        pushb(8'(cnt >> 8), 0);
        pushb(8'(cnt), 0);
        pushb({7'b0, err}, 0);
        pushb(8'h00, 1);
    endtask

    task automatic run(input int ntrig, input bit st);
        int base;
        int nexp;
        rxq.delete(); rxl.delete(); expq.delete(); expl.delete();
        trig_ts.delete(); trig_fid.delete();
        stall = st;
        base = nlast;
        for (int j = 0; j < LAT + 3; j++) drive(pat[j], j == LAT + 2);
        for (int j = 1; j < ntrig; j++) drive(8'h00, 1'b1);
        nexp = (ntrig < TQ + 1) ? ntrig : TQ + 1;
        for (int i = 0; i < nexp; i++) build(trig_ts[i], trig_fid[i], (i == 0) && (ntrig > TQ + 1));
        for (int g = 0; g < 3000 && nlast < base + nexp; g++) drive(8'h00, 1'b0);
        for (int g = 0; g < 4; g++) drive(8'h00, 1'b0);
        stall = 1'b0;
        nframes = nlast - base;
    endtask

    task automatic cmp(input string req);
        int bad;
        int n;
        bad = -1;
        n = (rxq.size() < expq.size()) ? rxq.size() : expq.size();
        for (int i = 0; i < n; i++) begin
            if (bad < 0 && (rxq[i] !== expq[i] || rxl[i] !== expl[i])) bad = i;
        end
        if (bad >= 0)
            check(1'b0, req, $sformatf("byte[%0d]=%h last=%0d", bad, rxq[bad], rxl[bad]),
                  $sformatf("%h last=%0d", expq[bad], expl[bad]));
        else
            check(rxq.size() == expq.size(), req, $sformatf("%0d bytes", rxq.size()),
                  $sformatf("%0d bytes", expq.size()));
    endtask

    task automatic fill_vec(input logic [31:0] v);
        int k;
        int i;
        k = int'($signed(v[23:16]));
        for (int j = 0; j < LAT + 3; j++) begin
            i = j - 2;
            pat[j] = (i >= k && i < k + int'(v[15:8])) ? v[31:24] : 8'h00;
        end
    endtask

    initial begin
        int nh;
        for (int i = 0; i < 4096; i++) hist[i] = 8'h00;
        repeat (4) @(posedge clk);
        #2;
        rst_i = 1'b0;
        tsn = 0;
        // R1: no output without a trigger
        for (int g = 0; g < 5; g++) drive(8'hFF, 1'b0);
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1 idle after reset", $sformatf("%0b", out_valid_o), "0");
        #2;
        for (int g = 0; g < 3; g++) drive(8'h00, 1'b0);

        // table of window placements: R2 R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            fill_vec(VEC[v]);
            run(1, 1'b0);
            cmp($sformatf("R2/R3/R4/R5/R7 vector %0d frame", v));
            nh = (rxq.size() >= 16) ? (rxq.size() - 16) / 2 : -1;
            check(nh == int'(VEC[v][7:0]), $sformatf("R3/R5 vector %0d entries", v),
                  $sformatf("%0d", nh), $sformatf("%0d", VEC[v][7:0]));
        end

        // R6: ordering, re-arm after gap
        for (int j = 0; j < LAT + 3; j++) pat[j] = 8'h00;
        pat[4]  = 8'h22;
        pat[9]  = 8'h08;
        pat[11] = 8'h09;
        pat[12] = 8'h01;
        pat[13] = 8'h01;
        run(1, 1'b0);
        cmp("R6 ordering frame");
        check(rxq.size() == 26 && rxq[12] == 8'd1 && rxq[14] == 8'd5 && rxq[16] == 8'd3,
              "R6 first channels", $sformatf("size %0d", rxq.size()), "26 bytes, ch 1,5,3");

        // R10: irregular backpressure
        fill_vec(VEC[7]);
        run(1, 1'b1);
        cmp("R10 stalled frame");

        // R8/R9: four triggers back to back
        fill_vec(VEC[1]);
        run(4, 1'b0);
        cmp("R8/R9 burst frames");
        check(nframes == TQ + 1, "R8 frame count", $sformatf("%0d", nframes), $sformatf("%0d", TQ + 1));

        // R9: flag clears, frame ID keeps counting dropped trigger
        fill_vec(VEC[0]);
        run(1, 1'b0);
        cmp("R9 frame after drop");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule